// File: doc/BRIEF.md
# Priority Interrupt Sequencer with Trap

This block decides which interrupt the processor core takes next. It arbitrates between one non-maskable software trap request and a vector of maskable peripheral requests. It keeps one pending flag for each source. It tracks whether a trap routine or a maskable routine is in progress. When it grants an interrupt, it sends the core a one-cycle take pulse together with the identifier of the chosen source.

The trap outranks everything else. It is taken in the cycle after it is requested, whatever the state of the global enable. A trap can nest over another trap and over a maskable routine. Maskable routines never nest: a maskable grant waits until the current maskable routine has returned and no trap is active. While the boot-mode flag is high, nothing is granted. Requests that arrive during boot mode are still recorded, one per source, and they are granted once boot mode ends. The global enable is an input to this block, so boot mode cannot change it.

The source identifier is an unsigned number. Maskable source `i` reports `i`. The trap reports `NUM_SRC`, which is 8 by default. The reset input is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `irq_sequencer`

## Requirements
- R1: If `trap_req_i` is high at a clock edge while `boot_i` is low, `take_o` is high and `src_id_o` equals `NUM_SRC` in the following cycle, and `trap_active_o` is set in that same cycle. This holds for any value of `gie_i`, any value of `mask_active_o` and an already active trap.
- R2: While `trap_active_o` is high, no maskable request is granted. Such requests stay pending. A further trap request is still granted.
- R3: While `mask_active_o` is high, no further maskable request is granted. The held requests stay pending.
- R4: `reti_i` clears `mask_active_o` at the next edge and has no effect on `trap_active_o`. `trap_active_o` falls only through exit strobes.
- R5: `trap_active_o` clears on the second of two `trap_exit_i` strobes sampled on consecutive edges. A single strobe, or two strobes separated by an idle cycle, leaves it set.
- R6: A maskable request is granted only at an edge where `gie_i` is high. While `gie_i` is low, the request stays pending, and it is granted once `gie_i` is high.
- R7: When several maskable requests are pending and eligible, the lowest-numbered one is granted, and `src_id_o` carries its index.
- R8: `take_o` is a pulse that lasts a single cycle for each grant. `src_id_o` is 0 whenever `take_o` is low.
- R9: While `boot_i` is high, `take_o` stays low. Trap and maskable requests that arrive in boot mode are held. After `boot_i` falls, the trap is granted first and the maskable requests follow, subject to R2, R3 and R6.
- R10: Several requests from a source that is already pending collapse into one. Each such source produces exactly one grant.
- R11: After reset, `take_o`, `src_id_o`, `trap_active_o` and `mask_active_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trap_req_i | input | 1 | Software trap request strobe |
| mask_req_i | input | NUM_SRC | Maskable request strobes, one per source |
| gie_i | input | 1 | Global interrupt enable for maskable sources |
| reti_i | input | 1 | Return-from-interrupt strobe that ends a maskable routine |
| trap_exit_i | input | 1 | Trap exit strobe; two on consecutive cycles end the trap routine |
| boot_i | input | 1 | Boot-mode lockout flag |
| take_o | output | 1 | Single-cycle take-interrupt pulse |
| src_id_o | output | ID_W | Identifier of the granted source, valid while take_o is high |
| trap_active_o | output | 1 | A trap routine is in progress |
| mask_active_o | output | 1 | A maskable routine is in progress |

## Verification
The bench starts a trap while a maskable routine is running, then nests a second trap over it, then issues a return-from-interrupt in the middle of the trap. A design that let the return clear the trap state, or that released a held maskable request too early, would show a grant with the wrong identifier at that point. Exit strobes are sent alone, with a gap between them, and back to back, so a design that counts non-adjacent strobes leaves the trap state at the wrong time. Repeated pulses from one source during boot mode must produce only one grant after boot ends, and the trap must come before the held maskable requests. A design that queued duplicate requests, or that dropped the held requests, gives an extra grant or a missing grant.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_MASK = 2'd1,
    GRANT_TRAP = 2'd2
  } grant_e;
endpackage

// File: rtl/irqs_pend.sv
// Bank of sticky pending flags; a clear in the same cycle as a set wins.
module irqs_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] eff_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      pend_d[g] = (pend_q[g] | set_i[g]) & ~clr_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (set_i[g] || clr_i[g]) begin
        pend_q[g] <= pend_d[g];
      end
    end
  end

  // The current request counts as pending in the cycle it arrives.
  assign eff_o = pend_q | set_i;
endmodule

// File: rtl/irqs_prio.sv
// Fixed-priority encoder: the lowest index wins.
module irqs_prio #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [N-1:0]    onehot_o,
  output logic [IDXW-1:0] idx_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1]   = seen[g] | req_i[g];
    assign onehot_o[g] = req_i[g] & ~seen[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) begin
        idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/irqs_state.sv
// Tracks the active trap and maskable routines and the trap exit handshake.
module irqs_state (
  input  logic clk,
  input  logic rst_n,
  input  logic take_trap_i,
  input  logic take_mask_i,
  input  logic reti_i,
  input  logic exit_i,
  output logic trap_active_o,
  output logic mask_active_o
);
  logic trap_q, trap_d;
  logic mask_q, mask_d;
  logic arm_q, arm_d;
  logic st_en;

  always_comb begin
    trap_d = trap_q;
    mask_d = mask_q;
    arm_d  = 1'b0;
    if (take_trap_i) begin
      trap_d = 1'b1;
    end else if (trap_q && exit_i) begin
      if (arm_q) begin
        trap_d = 1'b0;
      end else begin
        arm_d = 1'b1;
      end
    end
    if (take_mask_i) begin
      mask_d = 1'b1;
    end else if (reti_i) begin
      mask_d = 1'b0;
    end
  end

  assign st_en = take_trap_i | take_mask_i | reti_i | exit_i | arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      mask_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (st_en) begin
      trap_q <= trap_d;
      mask_q <= mask_d;
      arm_q  <= arm_d;
    end
  end

  assign trap_active_o = trap_q;
  assign mask_active_o = mask_q;
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter  int NUM_SRC = 8,
  localparam int ID_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req_i,
  input  logic [NUM_SRC-1:0] mask_req_i,
  input  logic               gie_i,
  input  logic               reti_i,
  input  logic               trap_exit_i,
  input  logic               boot_i,
  output logic               take_o,
  output logic [ID_W-1:0]    src_id_o,
  output logic               trap_active_o,
  output logic               mask_active_o
);
  import irqs_pkg::*;

  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] TRAP_ID = ID_W'(NUM_SRC);

  // Reset synchroniser: assertion is asynchronous, release follows the clock.
  logic rst_s1_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  logic [NUM_SRC-1:0] mask_eff, mask_onehot, mask_clr;
  logic               mask_any;
  logic [IDXW-1:0]    mask_idx;
  logic [0:0]         trap_eff, trap_clr;
  grant_e             grant;

  irqs_pend #(.N(NUM_SRC)) u_mpend (
    .clk  (clk),
    .rst_n(rst_q_n),
    .set_i(mask_req_i),
    .clr_i(mask_clr),
    .eff_o(mask_eff)
  );

  irqs_pend #(.N(1)) u_tpend (
    .clk  (clk),
    .rst_n(rst_q_n),
    .set_i(trap_req_i),
    .clr_i(trap_clr),
    .eff_o(trap_eff)
  );

  irqs_prio #(.N(NUM_SRC), .IDXW(IDXW)) u_prio (
    .req_i   (mask_eff),
    .any_o   (mask_any),
    .onehot_o(mask_onehot),
    .idx_o   (mask_idx)
  );

  // Grant decision: the trap outranks everything, boot mode blocks all.
  always_comb begin
    grant = GRANT_NONE;
    if (!boot_i) begin
      if (trap_eff[0]) begin
        grant = GRANT_TRAP;
      end else if (gie_i && mask_any && !trap_active_o && !mask_active_o) begin
        grant = GRANT_MASK;
      end
    end
  end

  assign trap_clr = (grant == GRANT_TRAP);
  assign mask_clr = (grant == GRANT_MASK) ? mask_onehot : '0;

  irqs_state u_state (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .take_trap_i  (grant == GRANT_TRAP),
    .take_mask_i  (grant == GRANT_MASK),
    .reti_i       (reti_i),
    .exit_i       (trap_exit_i),
    .trap_active_o(trap_active_o),
    .mask_active_o(mask_active_o)
  );

  logic            take_d;
  logic [ID_W-1:0] id_d;
  logic            out_en;

  always_comb begin
    take_d = (grant != GRANT_NONE);
    unique case (grant)
      GRANT_TRAP: id_d = TRAP_ID;
      GRANT_MASK: id_d = ID_W'(mask_idx);
      default:    id_d = '0;
    endcase
  end

  assign out_en = take_d | take_o;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      take_o   <= 1'b0;
      src_id_o <= '0;
    end else if (out_en) begin
      take_o   <= take_d;
      src_id_o <= id_d;
    end
  end
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter  int NUM_SRC = 8,
  localparam int ID_W    = $clog2(NUM_SRC + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_req_i,
  input logic [NUM_SRC-1:0] mask_req_i,
  input logic               gie_i,
  input logic               reti_i,
  input logic               trap_exit_i,
  input logic               boot_i,
  input logic               take_o,
  input logic [ID_W-1:0]    src_id_o,
  input logic               trap_active_o,
  input logic               mask_active_o
);
  localparam logic [ID_W-1:0] TRAP_ID = ID_W'(NUM_SRC);

  logic mask_take;
  assign mask_take = take_o && (src_id_o != TRAP_ID);

  AST_TRAP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && !boot_i) |=> (take_o && src_id_o == TRAP_ID)); // R1
  AST_TRAP_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_id_o == TRAP_ID) |-> trap_active_o); // R1
  AST_TRAP_BLOCKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_active_o |=> !mask_take); // R2
  AST_MASK_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    mask_active_o |=> !mask_take); // R3
  AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_active_o && !trap_exit_i) |=> trap_active_o); // R4
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !mask_take); // R6
  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (src_id_o == '0)); // R8
  AST_BOOT_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    boot_i |=> !take_o); // R9
endmodule

bind irq_sequencer irq_sequencer_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .trap_req_i   (trap_req_i),
  .mask_req_i   (mask_req_i),
  .gie_i        (gie_i),
  .reti_i       (reti_i),
  .trap_exit_i  (trap_exit_i),
  .boot_i       (boot_i),
  .take_o       (take_o),
  .src_id_o     (src_id_o),
  .trap_active_o(trap_active_o),
  .mask_active_o(mask_active_o)
);

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N + 1);
  localparam logic [IW-1:0] TID = IW'(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trap_req, gie, reti, texit, boot;
  logic [N-1:0]  mreq;
  logic          take, ta, ma;
  logic [IW-1:0] sid;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_sequencer #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .mask_req_i(mreq),
    .gie_i(gie), .reti_i(reti), .trap_exit_i(texit), .boot_i(boot),
    .take_o(take), .src_id_o(sid), .trap_active_o(ta), .mask_active_o(ma)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_out(input logic e_take, input logic [IW-1:0] e_id,
                            input logic e_ta, input logic e_ma, input string tag);
    n_chk++;
    if (take !== e_take || sid !== e_id || ta !== e_ta || ma !== e_ma) begin
      n_bad++;
      $display("FAIL %s: take=%b id=%0d ta=%b ma=%b expected take=%b id=%0d ta=%b ma=%b",
               tag, take, sid, ta, ma, e_take, e_id, e_ta, e_ma);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; trap_req = 0; gie = 0; reti = 0; texit = 0; boot = 0; mreq = '0;
    repeat (3) step();
    expect_out(0, 0, 0, 0, "R11 in reset");
    rst_n = 1'b1;
    repeat (3) step();
    expect_out(0, 0, 0, 0, "R11 after release");
  endtask

  task automatic t_trap_exit();
    gie = 0; trap_req = 1; step(); trap_req = 0;
    expect_out(1, TID, 1, 0, "R1 trap with gie low");
    step();
    expect_out(0, 0, 1, 0, "R8 single pulse");
    texit = 1; step(); texit = 0; step();
    expect_out(0, 0, 1, 0, "R5 lone strobe keeps trap");
    texit = 1; step(); texit = 0; step();
    expect_out(0, 0, 1, 0, "R5 split strobes keep trap");
    texit = 1; step();
    expect_out(0, 0, 1, 0, "R5 first of pair");
    step(); texit = 0;
    expect_out(0, 0, 0, 0, "R5 second of pair clears");
  endtask

  task automatic t_priority();
    gie = 1; mreq = 8'b0010_1100; step(); mreq = '0;
    expect_out(1, 2, 0, 1, "R7 lowest index wins");
    step();
    expect_out(0, 0, 0, 1, "R8 pulse ends");
    repeat (3) step();
    expect_out(0, 0, 0, 1, "R3 held while routine active");
    reti = 1; step(); reti = 0;
    expect_out(0, 0, 0, 0, "R4 reti clears mask state");
    step();
    expect_out(1, 3, 0, 1, "R7 next pending");
    reti = 1; step(); reti = 0; step();
    expect_out(1, 5, 0, 1, "R7 last pending");
    reti = 1; step(); reti = 0; step();
    expect_out(0, 0, 0, 0, "R3 queue empty");
  endtask

  task automatic t_gie();
    gie = 0; mreq = 8'b0000_0010; step(); mreq = '0;
    repeat (2) step();
    expect_out(0, 0, 0, 0, "R6 gie low holds request");
    gie = 1; step();
    expect_out(1, 1, 0, 1, "R6 granted when gie high");
    reti = 1; step(); reti = 0; step();
    expect_out(0, 0, 0, 0, "R6 idle after return");
  endtask

  task automatic t_preempt();
    gie = 1; mreq = 8'b0000_0001; step(); mreq = '0;
    expect_out(1, 0, 0, 1, "R7 source 0");
    trap_req = 1; step(); trap_req = 0;
    expect_out(1, TID, 1, 1, "R1 trap pre-empts maskable");
    mreq = 8'b0001_0000; step(); mreq = '0; step();
    expect_out(0, 0, 1, 1, "R2 maskable held under trap");
    trap_req = 1; step(); trap_req = 0;
    expect_out(1, TID, 1, 1, "R2 trap nests over trap");
    reti = 1; step(); reti = 0;
    expect_out(0, 0, 1, 0, "R4 reti leaves trap set");
    step();
    expect_out(0, 0, 1, 0, "R2 still held with mask idle");
    texit = 1; step(); step(); texit = 0;
    expect_out(0, 0, 0, 0, "R5 exit pair");
    step();
    expect_out(1, 4, 0, 1, "R2 held request released");
    reti = 1; step(); reti = 0; step();
  endtask

  task automatic t_boot();
    gie = 1; boot = 1;
    mreq = 8'b0100_0000; step(); step();
    mreq = 8'b1100_0000; trap_req = 1; step();
    mreq = 8'b0100_0000; trap_req = 0; step(); mreq = '0; step();
    expect_out(0, 0, 0, 0, "R9 no grant in boot");
    boot = 0; step();
    expect_out(1, TID, 1, 0, "R9 held trap first");
    texit = 1; step();
    expect_out(0, 0, 1, 0, "R9 maskable waits for trap");
    step(); texit = 0;
    expect_out(0, 0, 0, 0, "R5 trap left");
    step();
    expect_out(1, 6, 0, 1, "R9 held source 6");
    reti = 1; step(); reti = 0; step();
    expect_out(1, 7, 0, 1, "R9 held source 7");
    reti = 1; step(); reti = 0; step();
    expect_out(0, 0, 0, 0, "R10 no duplicate of source 6");
    step();
    expect_out(0, 0, 0, 0, "R10 still idle");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_trap_exit();
        t_priority();
        t_gie();
        t_preempt();
        t_boot();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule